// File: doc/BRIEF.md
# Receive Queue Control and Interrupt Logic

This block tracks what sits in a receive frame buffer and decides when the host should be told about it. Each frame arrival adds one to a frame counter and its length to a byte counter. A small queue records the lengths in arrival order, so that the correct number of bytes can be taken off when the oldest frame leaves. Two programmable thresholds, one on bytes and one on frames, can each raise a sticky receive interrupt. The host clears that interrupt by writing a 1 to it.

The oldest frame leaves the buffer in one of two ways. With auto-dequeue on, the event that says the host has finished reading it releases it. A release command written by the host frees it explicitly, which is how an erroneous frame is discarded. Either way a one-cycle dequeue strobe tells the buffer side to move its read pointer to the next frame. A direct-memory mode routes data-phase bus cycles (command pin low) straight to the buffer. While that mode is on, every register except the control register is locked.

Top module: `rxq_ctl`

## Requirements
- R1: With control bit 0 set, the interrupt flag rises on the clock edge after the byte count first becomes strictly greater than the byte threshold (register select 1). A count equal to the threshold does not raise it, and with bit 0 clear the byte count never raises it.
- R2: With control bit 1 set, the interrupt flag rises on the clock edge after the frame count becomes strictly greater than the frame threshold (register select 2). The flag reads back in bit 13 of the status register (select 3) and drives `rx_irq`.
- R3: The interrupt flag stays set when the counts later fall and when 0 is written to status bit 13. Writing 1 to bit 13 clears it on the next edge, unless a threshold condition is still true, in which case the flag stays set.
- R4: With control bit 2 (auto-dequeue) set, a `frm_done` pulse while at least one frame is held removes the oldest frame on that edge. `deq_stb` is high for the following cycle, the frame count falls by one and the byte count falls by that frame's length.
- R5: With control bit 2 clear, or with no frame held, `frm_done` changes no count and produces no `deq_stb`.
- R6: While control bit 3 (DMA mode) is 1, a bus cycle with `bus_cs` high and `bus_cmd` low drives `buf_rd` or `buf_wr` from the matching strobe. While bit 3 is 0, both stay low.
- R7: While control bit 3 is 1, `reg_en` is low. Writes to selects 1 to 3 have no effect and reads of selects 1 to 5 return 0. The control register (select 0) can still be read and written.
- R8: Writing 0 to control bit 3 restores `reg_en` and normal access to every register, and the earlier contents are unchanged.
- R9: Writing 1 to control bit 4 requests a release. The bit reads 1 until the edge after the write, when the oldest frame is removed (counts drop as in R4, `deq_stb` pulses) and the bit clears itself.
- R10: A release requested while no frame is held clears bit 4 on the next edge, with no `deq_stb` and no change in either count.
- R11: At most 2^AW frames are held; an arrival while full is dropped and changes neither count.
- R12: Select 4 reads the byte count and select 5 the frame count, both 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Host chip select |
| bus_cmd | input | 1 | 1 = register cycle, 0 = data cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register |
| frm_arrive | input | 1 | A frame has been stored in the buffer |
| frm_len | input | LEN_W | Byte length of the arriving frame |
| frm_done | input | 1 | Host has finished reading the oldest frame |
| rx_irq | output | 1 | Sticky receive interrupt flag |
| deq_stb | output | 1 | One-cycle pulse: oldest frame removed |
| reg_en | output | 1 | Register access enabled (DMA mode off) |
| buf_rd | output | 1 | DMA read of the buffer |
| buf_wr | output | 1 | DMA write of the buffer |

## Verification
The assertions take for granted that every strobe is a one-cycle pulse driven between clock edges, and that reset is held for several cycles, so that every `$past` sees reset values. They also assume the host never writes the release bit and the status clear in the same cycle as a bus data cycle. The stimulus pulses each event for exactly one cycle, drives only one bus cycle at a time, and holds frame lengths small enough that the byte count cannot wrap.

// File: rtl/rxq_ctl.sv
module rxq_ctl #(
  parameter int AW    = 3,
  parameter int LEN_W = 11,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic             bus_cmd,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [2:0]       bus_sel,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             frm_arrive,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_done,
  output logic             rx_irq,
  output logic             deq_stb,
  output logic             reg_en,
  output logic             buf_rd,
  output logic             buf_wr
);
  localparam int DEPTH = 1 << AW;
  localparam int FCW   = AW + 1;
  localparam int BCW   = LEN_W + AW + 1;
  localparam int IRQ_B = 13;

  logic [4:0]       ctrl_q;
  logic [BCW-1:0]   bthr_q, bcnt_q;
  logic [FCW-1:0]   fthr_q, fcnt_q;
  logic [AW-1:0]    wp_q, rp_q;
  logic [LEN_W-1:0] lenq [DEPTH];
  logic             irq_q, deq_q;

  wire dma      = ctrl_q[3];
  wire reg_cyc  = bus_cs & bus_cmd;
  wire data_cyc = bus_cs & ~bus_cmd;
  wire wr_ctrl  = reg_cyc & bus_wr & (bus_sel == 3'd0);
  wire wr_open  = reg_cyc & bus_wr & ~dma;
  wire rd_open  = reg_cyc & bus_rd & ~dma;
  wire clr_irq  = wr_open & (bus_sel == 3'd3) & bus_wdata[IRQ_B];

  wire held     = (fcnt_q != '0);
  wire push     = frm_arrive & (fcnt_q != FCW'(DEPTH));
  wire auto_pop = frm_done & ctrl_q[2] & held;
  wire rel_go   = ctrl_q[4] & ~auto_pop;
  wire pop      = auto_pop | (rel_go & held);
  wire hit      = (ctrl_q[0] & (bcnt_q > bthr_q)) | (ctrl_q[1] & (fcnt_q > fthr_q));

  wire [BCW-1:0] add_b = push ? BCW'(frm_len) : '0;
  wire [BCW-1:0] sub_b = pop  ? BCW'(lenq[rp_q]) : '0;

  assign reg_en  = ~dma;
  assign buf_rd  = data_cyc & bus_rd & dma;
  assign buf_wr  = data_cyc & bus_wr & dma;
  assign rx_irq  = irq_q;
  assign deq_stb = deq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      bthr_q <= '0;
      fthr_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q[3:0] <= bus_wdata[3:0];
      ctrl_q[4] <= (ctrl_q[4] & ~rel_go) | (wr_ctrl & bus_wdata[4]);
      if (wr_open && bus_sel == 3'd1) bthr_q <= bus_wdata[BCW-1:0];
      if (wr_open && bus_sel == 3'd2) fthr_q <= bus_wdata[FCW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (push) lenq[wp_q] <= frm_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fcnt_q <= '0;
      bcnt_q <= '0;
      deq_q  <= 1'b0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      fcnt_q <= fcnt_q + FCW'(push) - FCW'(pop);
      bcnt_q <= bcnt_q + add_b - sub_b;
      deq_q  <= pop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (hit)     irq_q <= 1'b1;
    else if (clr_irq) irq_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (reg_cyc && bus_rd && bus_sel == 3'd0) bus_rdata = DW'(ctrl_q);
    else if (rd_open) begin
      case (bus_sel)
        3'd1:    bus_rdata = DW'(bthr_q);
        3'd2:    bus_rdata = DW'(fthr_q);
        3'd3:    bus_rdata[IRQ_B] = irq_q;
        3'd4:    bus_rdata = DW'(bcnt_q);
        3'd5:    bus_rdata = DW'(fcnt_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_frame_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= FCW'(DEPTH));

  assert_deq_had_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    deq_q |-> $past(fcnt_q) != '0);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt_q == $past(fcnt_q)) || (fcnt_q == $past(fcnt_q) + 1'b1) || (fcnt_q == $past(fcnt_q) - 1'b1));

  assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_irq) |=> irq_q);

  assert_lock_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma && reg_cyc && bus_wr && bus_sel != 3'd0) |=> ($stable(bthr_q) && $stable(fthr_q)));

  assert_rel_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && !auto_pop && !wr_ctrl) |=> !ctrl_q[4]);

  assert_empty_rel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && !held && !frm_arrive) |=> (!deq_q && bcnt_q == $past(bcnt_q)));
endmodule

// File: tb/sim_rxq_ctl.sv
module sim_rxq_ctl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_cmd = 0, bus_rd = 0, bus_wr = 0;
  logic [2:0] bus_sel = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic frm_arrive = 0, frm_done = 0;
  logic [10:0] frm_len = 0;
  logic rx_irq, deq_stb, reg_en, buf_rd, buf_wr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rxq_ctl u0 (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(); tick(); tick(); rst_n = 1;
  endtask

  task automatic wr(input int sel, input int d);
    bus_cs = 1; bus_cmd = 1; bus_wr = 1; bus_sel = 3'(sel); bus_wdata = 16'(d);
    tick();
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd(input int sel, output int d);
    bus_cs = 1; bus_cmd = 1; bus_rd = 1; bus_sel = 3'(sel);
    #1 d = int'(bus_rdata);
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic arrive(input int len);
    frm_arrive = 1; frm_len = 11'(len);
    tick();
    frm_arrive = 0;
  endtask

  task automatic done();
    frm_done = 1;
    tick();
    frm_done = 0;
  endtask

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, bsum, nf, seen;
    do_reset();
    chk("R12 reset irq", int'(rx_irq), 0);
    chk("R12 reset deq", int'(deq_stb), 0);
    chk("R7 reset reg_en", int'(reg_en), 1);
    rd(4, v); chk("R12 reset bytes", v, 0);
    rd(5, v); chk("R12 reset frames", v, 0);

    // R11 fill and overflow
    bsum = 0;
    for (int i = 0; i < 8; i++) begin arrive(10 + i); bsum += 10 + i; end
    rd(5, v); chk("R11 full frames", v, 8);
    rd(4, v); chk("R12 full bytes", v, bsum);
    arrive(99);
    rd(5, v); chk("R11 dropped frames", v, 8);
    rd(4, v); chk("R11 dropped bytes", v, bsum);

    // R5 done ignored without auto-dequeue
    done();
    chk("R5 no deq", int'(deq_stb), 0);
    rd(5, v); chk("R5 frames kept", v, 8);

    // R4 drain in order
    wr(0, 4);
    for (int i = 0; i < 8; i++) begin
      done();
      bsum -= 10 + i;
      chk("R4 deq pulse", int'(deq_stb), 1);
      rd(5, v); chk("R4 frames", v, 7 - i);
      rd(4, v); chk("R4 bytes", v, bsum);
      tick();
      chk("R4 deq one cycle", int'(deq_stb), 0);
    end
    done();
    chk("R5 empty no deq", int'(deq_stb), 0);
    rd(4, v); chk("R5 empty bytes", v, 0);

    // R1 byte threshold sweep
    for (int thr = 0; thr <= 42; thr += 3) begin
      do_reset();
      wr(1, thr); wr(0, 1);
      bsum = 0;
      for (int k = 0; k < 6; k++) begin
        arrive(7); bsum += 7; tick();
        chk("R1 byte irq", int'(rx_irq), int'(bsum > thr));
      end
    end
    do_reset();
    wr(1, 0);
    arrive(5); tick(); tick();
    chk("R1 disabled", int'(rx_irq), 0);

    // R2 frame threshold sweep
    for (int thr = 0; thr <= 8; thr++) begin
      do_reset();
      wr(2, thr); wr(0, 2);
      for (int k = 1; k <= 8; k++) begin
        arrive(1); tick();
        chk("R2 frame irq", int'(rx_irq), int'(k > thr));
      end
      rd(3, v); chk("R2 status bit13", v, (thr < 8) ? 8192 : 0);
    end

    // R3 sticky and clearing
    do_reset();
    wr(2, 0); wr(0, 6);
    arrive(3); tick();
    chk("R3 set", int'(rx_irq), 1);
    done(); tick();
    chk("R3 held after fall", int'(rx_irq), 1);
    wr(3, 0); tick();
    chk("R3 write0 no clear", int'(rx_irq), 1);
    arrive(3); arrive(3); tick();
    wr(3, 8192); tick();
    chk("R3 set wins", int'(rx_irq), 1);
    wr(0, 0); wr(3, 8192);
    chk("R3 cleared", int'(rx_irq), 0);
    rd(3, v); chk("R3 status clear", v, 0);

    // R6 R7 R8 DMA lock
    do_reset();
    wr(1, 5); wr(2, 0); wr(0, 2);
    arrive(4); tick();
    chk("R7 pre irq", int'(rx_irq), 1);
    wr(0, 8);
    chk("R7 reg_en low", int'(reg_en), 0);
    bus_cs = 1; bus_cmd = 0; bus_rd = 1; #1;
    chk("R6 buf_rd", int'(buf_rd), 1);
    chk("R6 buf_wr idle", int'(buf_wr), 0);
    bus_rd = 0; bus_wr = 1; #1;
    chk("R6 buf_wr", int'(buf_wr), 1);
    bus_wr = 0; bus_cs = 0;
    wr(1, 9);
    rd(1, v); chk("R7 blocked read", v, 0);
    rd(5, v); chk("R7 blocked count", v, 0);
    rd(0, v); chk("R7 ctrl readable", v, 8);
    wr(3, 8192); tick();
    chk("R7 clear blocked", int'(rx_irq), 1);
    wr(0, 0);
    chk("R8 reg_en back", int'(reg_en), 1);
    rd(1, v); chk("R8 thr kept", v, 5);
    rd(5, v); chk("R8 frames visible", v, 1);
    bus_cs = 1; bus_cmd = 0; bus_rd = 1; #1;
    chk("R6 no dma buf_rd", int'(buf_rd), 0);
    bus_cs = 0; bus_rd = 0;
    wr(3, 8192);
    chk("R8 clear works", int'(rx_irq), 0);

    // R9 release
    do_reset();
    arrive(20); arrive(30);
    wr(0, 16);
    rd(0, v); chk("R9 pending", v, 16);
    tick();
    chk("R9 deq", int'(deq_stb), 1);
    rd(0, v); chk("R9 self clear", v, 0);
    rd(5, v); chk("R9 frames", v, 1);
    rd(4, v); chk("R9 bytes", v, 30);

    // R10 empty release
    do_reset();
    wr(0, 16);
    rd(0, v); chk("R10 pending", v, 16);
    tick();
    chk("R10 no deq", int'(deq_stb), 0);
    rd(0, v); chk("R10 cleared", v, 0);
    rd(4, v); chk("R10 bytes", v, 0);
    rd(5, v); chk("R10 frames", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule